// File: doc/BRIEF.md
# Flash Block-Erase Sequencer

This block walks the control bits of an on-chip flash array through a complete block erase. After a start request it raises the write-enable bit and then the setup bit. It applies a timed erase pulse and drops the erase and setup bits. It then enters verify mode, issues a one-cycle dummy-write strobe and samples a pass/fail input from the array's verify logic. A failed verify triggers another pulse until either a pass is seen or the attempt budget is spent. The write-enable bit is then cleared and the result is reported.

Every bit change is followed by a minimum settling interval. Each interval is set in microseconds and turned into clock cycles from a clock-frequency parameter given in kHz, rounded up, with a floor of one cycle. A single down-counter times all the waits. The attempt budget is the smallest of three limits: a configured count, a hard cap of 120, and the number of whole pulses that fit into a total erase-time allowance. Only pulse time counts against that allowance.

Top module: `flash_erase_seq`

## Requirements
- R1: While reset is held, and in the cycle after it, every output is 0: swe_o, esu_o, ers_o, ev_o, dummy_wr_o, busy_o, done_o and err_o.
- R2: A start_i sampled high in idle sets busy_o and swe_o on the same clock edge. esu_o stays low until 1 µs of cycles have elapsed.
- R3: Every step lasts exactly ceil(t_us × CLK_KHZ / 1000) cycles, with a minimum of 1. The step times are: write-enable set 1 µs, setup set 100 µs, erase cleared 10 µs, setup cleared 10 µs, verify set 20 µs, after dummy write 2 µs, verify cleared 4 µs, write-enable cleared 100 µs. In particular esu_o rises 100 µs of cycles before ers_o.
- R4: ers_o stays high for PULSE_US of cycles per attempt, with PULSE_US clamped to 10 000–100 000 µs. ers_o is high only while esu_o and swe_o are high.
- R5: ev_o is high for 22 µs of cycles per attempt and is never high together with esu_o. dummy_wr_o pulses for one cycle, while ev_o is high, as the first cycle after the 20 µs verify wait. verify_ok_i is sampled in the last cycle of the 2 µs wait.
- R6: After a failed verify with attempts left, the sequencer returns to setting the setup bit. The attempt limit is min(MAX_TRIES, 120, floor(MAX_TOTAL_US / pulse)), with a minimum of 1.
- R7: After the last verify clear, swe_o drops and 100 µs of cycles follow. Then done_o pulses for one cycle with busy_o low. err_o is high in that same cycle only if no verify passed.
- R8: start_i while busy_o is high has no effect on the sequence or its total duration.
- R9: A synchronous reset in mid-erase clears all bits and returns the block to idle on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin a block erase |
| verify_ok_i | input | 1 | Verify result from the array (1 = block reads erased) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion strobe |
| err_o | output | 1 | Valid with done_o: attempts exhausted without a pass |
| swe_o | output | 1 | Software write-enable bit |
| esu_o | output | 1 | Erase-setup bit |
| ers_o | output | 1 | Erase bit (pulse active) |
| ev_o | output | 1 | Erase-verify bit |
| dummy_wr_o | output | 1 | One-cycle dummy-write strobe |

## Verification
The assertions assume that verify_ok_i is settled whenever it matters, which is the last cycle of the post-dummy wait. They also assume that start_i may arrive at any time, and that reset may arrive in any step. The bench drives verify_ok_i only from the number of erase pulses it has seen so far. The input therefore changes only at a pulse's rising edge, well before any sample point. start_i is pulsed both in idle and deep inside an erase pulse, and reset is applied once in the middle of a pulse.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SWE_SET,
        ST_ESU_SET,
        ST_ERS_ON,
        ST_ERS_OFF,
        ST_ESU_OFF,
        ST_EV_SET,
        ST_DUMMY,
        ST_EV_OFF,
        ST_SWE_OFF
    } step_e;

    typedef struct packed {
        logic swe;
        logic esu;
        logic ers;
        logic ev;
    } ctrl_bits_t;

    localparam int unsigned T_SWE_SET_US = 1;
    localparam int unsigned T_ESU_SET_US = 100;
    localparam int unsigned T_ERS_OFF_US = 10;
    localparam int unsigned T_ESU_OFF_US = 10;
    localparam int unsigned T_EV_SET_US  = 20;
    localparam int unsigned T_DUMMY_US   = 2;
    localparam int unsigned T_EV_OFF_US  = 4;
    localparam int unsigned T_SWE_OFF_US = 100;
    localparam int unsigned PULSE_MIN_US = 10000;
    localparam int unsigned PULSE_MAX_US = 100000;
    localparam int unsigned TRIES_CAP    = 120;

    function automatic longint unsigned us_to_cycles(longint unsigned us,
                                                     longint unsigned khz);
        longint unsigned c;
        c = (us * khz + 64'd999) / 64'd1000;
        return (c == 0) ? 64'd1 : c;
    endfunction

    function automatic ctrl_bits_t bits_of(step_e s);
        ctrl_bits_t b;
        b = '0;
        case (s)
            ST_SWE_SET, ST_ESU_OFF, ST_EV_OFF: b.swe = 1'b1;
            ST_ESU_SET, ST_ERS_OFF: begin b.swe = 1'b1; b.esu = 1'b1; end
            ST_ERS_ON: begin b.swe = 1'b1; b.esu = 1'b1; b.ers = 1'b1; end
            ST_EV_SET, ST_DUMMY: begin b.swe = 1'b1; b.ev = 1'b1; end
            default: b = '0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/flash_erase_timer.sv
module flash_erase_timer #(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [TW-1:0] val_i,
    output logic          expired_o
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load_i)
            cnt <= val_i - TW'(1);
        else if (cnt != '0)
            cnt <= cnt - TW'(1);
    end

    assign expired_o = (cnt == '0);

    // The FSM only reloads once a wait has run out, so a running wait keeps counting down
    assert_count_down_R3: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |=> (cnt == $past(cnt) - TW'(1)));

endmodule

// File: rtl/flash_erase_ctl.sv
module flash_erase_ctl
    import flash_erase_pkg::*;
#(
    parameter int unsigned TW       = 8,
    parameter int unsigned TRY_LIM  = 4,
    parameter int unsigned TRY_W    = 3,
    parameter int unsigned CLK_KHZ  = 1000,
    parameter int unsigned PULSE_US = 10000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          verify_ok_i,
    input  logic          expired_i,
    output logic          load_o,
    output logic [TW-1:0] load_val_o,
    output ctrl_bits_t    bits_o,
    output logic          dummy_wr_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          err_o
);
    localparam logic [TW-1:0] C_SWE_SET = TW'(us_to_cycles(T_SWE_SET_US, CLK_KHZ));
    localparam logic [TW-1:0] C_ESU_SET = TW'(us_to_cycles(T_ESU_SET_US, CLK_KHZ));
    localparam logic [TW-1:0] C_PULSE   = TW'(us_to_cycles(PULSE_US,     CLK_KHZ));
    localparam logic [TW-1:0] C_ERS_OFF = TW'(us_to_cycles(T_ERS_OFF_US, CLK_KHZ));
    localparam logic [TW-1:0] C_ESU_OFF = TW'(us_to_cycles(T_ESU_OFF_US, CLK_KHZ));
    localparam logic [TW-1:0] C_EV_SET  = TW'(us_to_cycles(T_EV_SET_US,  CLK_KHZ));
    localparam logic [TW-1:0] C_DUMMY   = TW'(us_to_cycles(T_DUMMY_US,   CLK_KHZ));
    localparam logic [TW-1:0] C_EV_OFF  = TW'(us_to_cycles(T_EV_OFF_US,  CLK_KHZ));
    localparam logic [TW-1:0] C_SWE_OFF = TW'(us_to_cycles(T_SWE_OFF_US, CLK_KHZ));

    step_e            step, nxt;
    logic [TRY_W-1:0] tries;
    logic             passed;

    function automatic logic [TW-1:0] wait_of(step_e s);
        case (s)
            ST_SWE_SET: return C_SWE_SET;
            ST_ESU_SET: return C_ESU_SET;
            ST_ERS_ON:  return C_PULSE;
            ST_ERS_OFF: return C_ERS_OFF;
            ST_ESU_OFF: return C_ESU_OFF;
            ST_EV_SET:  return C_EV_SET;
            ST_DUMMY:   return C_DUMMY;
            ST_EV_OFF:  return C_EV_OFF;
            ST_SWE_OFF: return C_SWE_OFF;
            default:    return TW'(1);
        endcase
    endfunction

    always_comb begin
        nxt = step;
        if (step == ST_IDLE) begin
            if (start_i) nxt = ST_SWE_SET;
        end else if (expired_i) begin
            case (step)
                ST_SWE_SET: nxt = ST_ESU_SET;
                ST_ESU_SET: nxt = ST_ERS_ON;
                ST_ERS_ON:  nxt = ST_ERS_OFF;
                ST_ERS_OFF: nxt = ST_ESU_OFF;
                ST_ESU_OFF: nxt = ST_EV_SET;
                ST_EV_SET:  nxt = ST_DUMMY;
                ST_DUMMY:   nxt = ST_EV_OFF;
                ST_EV_OFF:  nxt = (passed || tries == TRY_W'(TRY_LIM)) ? ST_SWE_OFF : ST_ESU_SET;
                default:    nxt = ST_IDLE;
            endcase
        end
    end

    assign load_o     = (nxt != step) && (nxt != ST_IDLE);
    assign load_val_o = wait_of(nxt);
    assign bits_o     = bits_of(step);
    assign busy_o     = (step != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            step       <= ST_IDLE;
            tries      <= '0;
            passed     <= 1'b0;
            dummy_wr_o <= 1'b0;
            done_o     <= 1'b0;
            err_o      <= 1'b0;
        end else begin
            step       <= nxt;
            dummy_wr_o <= (nxt == ST_DUMMY) && (step != ST_DUMMY);
            done_o     <= (step == ST_SWE_OFF) && expired_i;
            err_o      <= (step == ST_SWE_OFF) && expired_i && !passed;
            if (step == ST_IDLE && start_i) begin
                tries  <= '0;
                passed <= 1'b0;
            end else begin
                if (nxt == ST_ERS_ON && step != ST_ERS_ON) tries <= tries + TRY_W'(1);
                if (step == ST_DUMMY && expired_i) passed <= verify_ok_i;
            end
        end
    end

    assert_ers_guard_R4: assert property (@(posedge clk) disable iff (rst)
        bits_o.ers |-> (bits_o.esu && bits_o.swe));
    assert_ev_excl_R5: assert property (@(posedge clk) disable iff (rst)
        bits_o.ev |-> !bits_o.esu);
    assert_dummy_in_ev_R5: assert property (@(posedge clk) disable iff (rst)
        dummy_wr_o |-> bits_o.ev);
    assert_tries_bound_R6: assert property (@(posedge clk) disable iff (rst)
        tries <= TRY_W'(TRY_LIM));
    assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && bits_o == '0));
    assert_err_with_done_R7: assert property (@(posedge clk) disable iff (rst)
        err_o |-> done_o);
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (start_i && busy_o && step != ST_SWE_SET) |=> (step != ST_SWE_SET));
    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (bits_o == '0 && !busy_o && !done_o && !dummy_wr_o));

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import flash_erase_pkg::*;
#(
    parameter int unsigned CLK_KHZ      = 50000,
    parameter int unsigned PULSE_US     = 10000,
    parameter int unsigned MAX_TRIES    = 120,
    parameter int unsigned MAX_TOTAL_US = 1200000
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic verify_ok_i,
    output logic busy_o,
    output logic done_o,
    output logic err_o,
    output logic swe_o,
    output logic esu_o,
    output logic ers_o,
    output logic ev_o,
    output logic dummy_wr_o
);
    localparam int unsigned PULSE_EFF =
        (PULSE_US < PULSE_MIN_US) ? PULSE_MIN_US :
        (PULSE_US > PULSE_MAX_US) ? PULSE_MAX_US : PULSE_US;
    localparam int unsigned FIT_TRIES = MAX_TOTAL_US / PULSE_EFF;
    localparam int unsigned LIM_A     = (MAX_TRIES < TRIES_CAP) ? MAX_TRIES : TRIES_CAP;
    localparam int unsigned LIM_B     = (LIM_A < FIT_TRIES) ? LIM_A : FIT_TRIES;
    localparam int unsigned TRY_LIM   = (LIM_B == 0) ? 1 : LIM_B;
    localparam int unsigned TRY_W     = $clog2(TRY_LIM + 1);
    localparam int unsigned TW        = $clog2(us_to_cycles(PULSE_MAX_US, CLK_KHZ) + 1);

    logic          load, expired;
    logic [TW-1:0] load_val;
    ctrl_bits_t    bits;

    flash_erase_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load),
        .val_i    (load_val),
        .expired_o(expired)
    );

    flash_erase_ctl #(
        .TW      (TW),
        .TRY_LIM (TRY_LIM),
        .TRY_W   (TRY_W),
        .CLK_KHZ (CLK_KHZ),
        .PULSE_US(PULSE_EFF)
    ) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .verify_ok_i(verify_ok_i),
        .expired_i  (expired),
        .load_o     (load),
        .load_val_o (load_val),
        .bits_o     (bits),
        .dummy_wr_o (dummy_wr_o),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .err_o      (err_o)
    );

    assign swe_o = bits.swe;
    assign esu_o = bits.esu;
    assign ers_o = bits.ers;
    assign ev_o  = bits.ev;

endmodule

// File: tb/flash_erase_seq_bench.sv
module flash_erase_seq_bench;
    // 500 kHz timing base: cycles = ceil(us / 2)
    function automatic int cyc(int us);
        return (us + 1) / 2;
    endfunction

    localparam int PULSE_C  = cyc(10000);
    localparam int PER_TRY  = cyc(100) + PULSE_C + cyc(10) + cyc(10) + cyc(20) + cyc(2) + cyc(4);
    localparam int GAP_C    = cyc(100);
    localparam int EV_W     = cyc(20) + cyc(2);
    localparam int LIMIT    = 4;  // 40000 us allowance / 10000 us pulse

    // pass_at (0 = never), expected attempts, expected err
    localparam int VEC [4][3] = '{'{1, 1, 0}, '{3, 3, 0}, '{0, LIMIT, 1}, '{LIMIT, LIMIT, 0}};

    logic clk = 0, rst = 1, start = 0;
    logic verify_ok;
    logic busy, done, err, swe, esu, ers, ev, dwr;
    int   n_tests = 0, n_fail = 0;
    int   pass_at = 0;
    bit   finished = 0;

    always #10 clk = ~clk;

    flash_erase_seq #(.CLK_KHZ(500), .PULSE_US(10000), .MAX_TRIES(120), .MAX_TOTAL_US(40000))
    u_flash_erase_seq (
        .clk(clk), .rst(rst), .start_i(start), .verify_ok_i(verify_ok),
        .busy_o(busy), .done_o(done), .err_o(err), .swe_o(swe), .esu_o(esu),
        .ers_o(ers), .ev_o(ev), .dummy_wr_o(dwr)
    );

    // monitor, sampled at the falling edge
    int attempts, ers_w, gap, ev_w, dummies, busy_n, bad_ers, bad_gap, bad_ev, bad_dwr;
    logic p_ers = 0, p_esu = 0, p_ev = 0;

    assign verify_ok = (pass_at != 0) && (attempts >= pass_at);

    task automatic mon_clear();
        attempts = 0; ers_w = 0; gap = 0; ev_w = 0; dummies = 0; busy_n = 0;
        bad_ers = 0; bad_gap = 0; bad_ev = 0; bad_dwr = 0;
    endtask

    always @(negedge clk) begin
        if (busy) busy_n++;
        if (ers && !p_ers) begin
            attempts++;
            if (gap != GAP_C) bad_gap++;
            ers_w = 1;
        end else if (ers) ers_w++;
        if (!ers && p_ers && ers_w != PULSE_C) bad_ers++;
        if (esu && !p_esu) gap = 1;
        else if (esu && !ers) gap++;
        if (ev && !p_ev) ev_w = 1;
        else if (ev) ev_w++;
        if (!ev && p_ev && ev_w != EV_W) bad_ev++;
        if (dwr) begin
            dummies++;
            if (!ev || ev_w != cyc(20) + 1) bad_dwr++;
        end
        p_ers = ers; p_esu = esu; p_ev = ev;
    end

    task automatic chk(bit ok, string req, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run(int pa, int k, int e, bit poke);
        int waited;
        pass_at = pa;
        mon_clear();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        chk(busy && swe && !esu, "R2 start sets swe", {busy, swe, esu}, 3'b110);
        waited = 0;
        while (!done && waited < 60000) begin
            @(negedge clk);
            waited++;
            if (poke && waited == 3000) start = 1;
            if (poke && waited == 3001) start = 0;
        end
        chk(done && !busy && !swe, "R7 done with busy low", {done, busy, swe}, 3'b100);
        chk(err == e, "R7 err flag", err, e);
        chk(attempts == k, "R6 attempt count", attempts, k);
        chk(busy_n == 1 + cyc(1) - 1 + k * PER_TRY + cyc(100),
            poke ? "R8 duration unchanged" : "R3 total duration", busy_n,
            1 + cyc(1) - 1 + k * PER_TRY + cyc(100));
        chk(bad_ers == 0, "R4 pulse width", bad_ers, 0);
        chk(bad_gap == 0, "R3 setup-to-erase gap", bad_gap, 0);
        chk(bad_ev == 0 && bad_dwr == 0 && dummies == k, "R5 verify window",
            dummies, k);
        @(negedge clk);
        chk(!done && !err, "R7 done one cycle", done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !err && !swe && !esu && !ers && !ev && !dwr,
            "R1 reset outputs", {busy, done, err, swe, esu, ers, ev, dwr}, 0);
        rst = 0;
        @(negedge clk);
        chk(!busy && !swe, "R1 after reset", {busy, swe}, 0);
        for (int i = 0; i < 4; i++) run(VEC[i][0], VEC[i][1], VEC[i][2], 1'b0);
        run(2, 2, 0, 1'b1);  // R8: start pulsed mid-pulse
        // R9: reset in the middle of a pulse
        pass_at = 1; mon_clear();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        repeat (300) @(negedge clk);
        chk(ers == 1, "R9 in pulse before reset", ers, 1);
        rst = 1;
        @(negedge clk); rst = 0;
        chk(!busy && !swe && !esu && !ers && !ev, "R9 reset clears bits",
            {busy, swe, esu, ers, ev}, 0);
        repeat (5) @(negedge clk);
        chk(!busy && !done, "R9 stays idle", {busy, done}, 0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule